// File: doc/BRIEF.md
# Pipeline hazard and forwarding unit

This block is the interlock and bypass controller for a five-stage in-order pipeline. The stages are fetch, decode, execute, memory and writeback. The pipeline reads register operands in the decode stage and also resolves branches there, so the bypass network feeds decode directly. For each of the two decode operands the block picks one of four sources: the register file, the execute-stage result, the memory-stage result or the writeback value. It also raises a stall when a needed value cannot be produced in time.

The stall applies to three places. The program counter and the fetch/decode register hold, and a no-op enters the execute stage. A branch does not squash the instruction fetched after it. That instruction is the delay slot and always runs, so the only control-flow output is a redirect strobe. A mode pin selects a legacy behaviour in which loaded data is usable only from writeback. In that mode a load followed directly by a dependent instruction costs two bubbles instead of one.

The block is purely combinational and has no clock or reset. Every output follows the stage descriptors on its inputs within the same cycle. The datapath applies the outputs at its next clock edge.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each operand select uses these codes: 0 = register file, 1 = execute result, 2 = memory-stage result, 3 = writeback value. When several stages write the operand's register, the youngest one wins, in the order execute, memory, writeback.
- R2: A source field of register 0 never selects a bypass and never causes a stall, whatever the producers hold.
- R3: An operand whose use flag is low has select 0 and causes no stall.
- R4: A used operand matching a load in execute stalls the pipeline. A stall drives hold_pc, hold_ifid and bubble_ex all high.
- R5: With legacy_mode low, a used operand matching a load in the memory stage (and no execute match) is bypassed from the memory stage (select 2) with no stall.
- R6: With legacy_mode high, a used operand matching a load in the memory stage (and no execute match) stalls. A match in writeback selects 3 without a stall. Non-load results still bypass from execute and memory.
- R7: With parameter BR_EX_STALL set (the default), a branch in decode whose used operand matches a non-load result in execute stalls. A non-branch with the same dependency takes select 1 and does not stall.
- R8: pc_redirect is high exactly when the branch-taken input is high and there is no stall. A redirect never holds the fetch/decode register, so the delay-slot instruction proceeds.
- R9: A producer whose write-enable is low is never matched, even when its load flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| legacy_mode | input | 1 | 1 = loaded data usable only from writeback |
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register of the decode instruction |
| id_use_rs | input | 1 | Decode instruction reads id_rs |
| id_use_rt | input | 1 | Decode instruction reads id_rt |
| id_branch | input | 1 | Decode instruction compares operands for a branch |
| id_branch_taken | input | 1 | Branch condition evaluated true in decode |
| ex_rd | input | 5 | Destination register in execute |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination register in memory stage |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Destination register in writeback |
| wb_wr | input | 1 | Writeback instruction writes a register |
| fwd_rs_sel | output | 2 | Source select for the first decode operand |
| fwd_rt_sel | output | 2 | Source select for the second decode operand |
| hold_pc | output | 1 | Keep the program counter |
| hold_ifid | output | 1 | Keep the fetch/decode register |
| bubble_ex | output | 1 | Load a no-op into the execute stage |
| pc_redirect | output | 1 | Load the branch target into the program counter |

## Verification
Every result is due in the same cycle as the descriptor that causes it, because no register lies between the inputs and outputs. The bench changes the descriptors on a falling clock edge and samples the outputs 1 ns later, well before the next rising edge. The datapath would consume the outputs at that rising edge, so each check sees the value the pipeline would act on. Multi-cycle effects, such as the two legacy bubbles, are checked one cycle at a time. The bench applies the descriptor of each cycle in turn and checks that cycle's stall.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
  parameter int unsigned REG_AW = 5;
  localparam int unsigned NUM_SRC = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_EX  = 2'd1,
    FWD_MEM = 2'd2,
    FWD_WB  = 2'd3
  } fwd_sel_e;

  typedef struct packed {
    logic [REG_AW-1:0] rd;
    logic              wr;
    logic              load;
  } producer_t;
endpackage

// File: rtl/hz_src_match.sv
`timescale 1ns/1ps
module hz_src_match
  import hz_pkg::*;
#(
  parameter bit BR_EX_STALL = 1'b1
) (
  input  logic [REG_AW-1:0] src,
  input  logic              use_src,
  input  logic              is_branch,
  input  logic              legacy,
  input  producer_t         p_ex,
  input  producer_t         p_mem,
  input  producer_t         p_wb,
  output fwd_sel_e          sel,
  output logic              stall_req
);
  logic live;
  logic hit_ex, hit_mem, hit_wb;

  assign live    = use_src && (src != '0);
  assign hit_ex  = live && p_ex.wr  && (p_ex.rd  == src);
  assign hit_mem = live && p_mem.wr && (p_mem.rd == src);
  assign hit_wb  = live && p_wb.wr  && (p_wb.rd  == src);

  always_comb begin
    if (hit_ex)       sel = FWD_EX;
    else if (hit_mem) sel = FWD_MEM;
    else if (hit_wb)  sel = FWD_WB;
    else              sel = FWD_RF;
  end

  always_comb begin
    stall_req = 1'b0;
    if (hit_ex) begin
      if (p_ex.load || (is_branch && BR_EX_STALL)) stall_req = 1'b1;
    end else if (hit_mem && p_mem.load && legacy) begin
      stall_req = 1'b1;
    end
  end
endmodule

// File: rtl/hz_stall_ctrl.sv
`timescale 1ns/1ps
module hz_stall_ctrl
  import hz_pkg::*;
(
  input  logic [NUM_SRC-1:0] stall_reqs,
  input  logic               branch_taken,
  output logic               hold_pc,
  output logic               hold_ifid,
  output logic               bubble_ex,
  output logic               pc_redirect
);
  logic stall;

  assign stall       = |stall_reqs;
  assign hold_pc     = stall;
  assign hold_ifid   = stall;
  assign bubble_ex   = stall;
  assign pc_redirect = branch_taken && !stall;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter bit BR_EX_STALL = 1'b1
) (
  input  logic              legacy_mode,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_use_rs,
  input  logic              id_use_rt,
  input  logic              id_branch,
  input  logic              id_branch_taken,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wr,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wr,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wr,
  output logic [1:0]        fwd_rs_sel,
  output logic [1:0]        fwd_rt_sel,
  output logic              hold_pc,
  output logic              hold_ifid,
  output logic              bubble_ex,
  output logic              pc_redirect
);
  producer_t p_ex, p_mem, p_wb;
  logic [REG_AW-1:0] src_arr [NUM_SRC];
  logic              use_arr [NUM_SRC];
  fwd_sel_e          sel_arr [NUM_SRC];
  logic [NUM_SRC-1:0] req_vec;

  assign p_ex  = '{rd: ex_rd,  wr: ex_wr,  load: ex_load};
  assign p_mem = '{rd: mem_rd, wr: mem_wr, load: mem_load};
  assign p_wb  = '{rd: wb_rd,  wr: wb_wr,  load: 1'b0};

  assign src_arr[0] = id_rs;
  assign src_arr[1] = id_rt;
  assign use_arr[0] = id_use_rs;
  assign use_arr[1] = id_use_rt;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hz_src_match #(.BR_EX_STALL(BR_EX_STALL)) u_match (
      .src       (src_arr[g]),
      .use_src   (use_arr[g]),
      .is_branch (id_branch),
      .legacy    (legacy_mode),
      .p_ex      (p_ex),
      .p_mem     (p_mem),
      .p_wb      (p_wb),
      .sel       (sel_arr[g]),
      .stall_req (req_vec[g])
    );
  end

  assign fwd_rs_sel = sel_arr[0];
  assign fwd_rt_sel = sel_arr[1];

  hz_stall_ctrl u_stall (
    .stall_reqs   (req_vec),
    .branch_taken (id_branch_taken),
    .hold_pc      (hold_pc),
    .hold_ifid    (hold_ifid),
    .bubble_ex    (bubble_ex),
    .pc_redirect  (pc_redirect)
  );
endmodule

// File: rtl/hz_chk.sv
`timescale 1ns/1ps
module hz_chk
  import hz_pkg::*;
(
  input logic              legacy_mode,
  input logic [REG_AW-1:0] id_rs,
  input logic              id_use_rs,
  input logic              id_branch,
  input logic              id_branch_taken,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_wr,
  input logic              ex_load,
  input logic              mem_wr,
  input logic [1:0]        fwd_rs_sel,
  input logic              hold_pc,
  input logic              hold_ifid,
  input logic              pc_redirect
);
  always_comb begin
    // R2
    zero_src_chk: assert (!(id_rs == '0) || fwd_rs_sel == FWD_RF)
      else $error("register 0 selected a bypass");
    // R3
    unused_src_chk: assert (id_use_rs || fwd_rs_sel == FWD_RF)
      else $error("unused operand selected a bypass");
    // R4
    load_use_chk: assert (!(id_use_rs && id_rs != '0 && ex_wr && ex_load && ex_rd == id_rs) || hold_pc)
      else $error("load-use in execute did not stall");
    // R5
    no_spurious_stall_chk: assert (legacy_mode || id_branch || (ex_wr && ex_load) || !hold_pc)
      else $error("stall without a cause");
    // R8
    redirect_chk: assert (pc_redirect == (id_branch_taken && !hold_pc))
      else $error("redirect disagrees with stall");
    // R8
    delay_slot_chk: assert (!pc_redirect || !hold_ifid)
      else $error("redirect held the delay slot");
    // R9
    idle_chk: assert (ex_wr || mem_wr || legacy_mode || !hold_pc)
      else $error("stall with no writers");
  end
endmodule

bind pipe_hazard_ctrl hz_chk u_hz_chk (
  .legacy_mode     (legacy_mode),
  .id_rs           (id_rs),
  .id_use_rs       (id_use_rs),
  .id_branch       (id_branch),
  .id_branch_taken (id_branch_taken),
  .ex_rd           (ex_rd),
  .ex_wr           (ex_wr),
  .ex_load         (ex_load),
  .mem_wr          (mem_wr),
  .fwd_rs_sel      (fwd_rs_sel),
  .hold_pc         (hold_pc),
  .hold_ifid       (hold_ifid),
  .pc_redirect     (pc_redirect)
);

// File: tb/pipe_hazard_ctrl_test.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       legacy_mode;
  logic [4:0] id_rs, id_rt;
  logic       id_use_rs, id_use_rt, id_branch, id_branch_taken;
  logic [4:0] ex_rd, mem_rd, wb_rd;
  logic       ex_wr, ex_load, mem_wr, mem_load, wb_wr;
  logic [1:0] fwd_rs_sel, fwd_rt_sel;
  logic       hold_pc, hold_ifid, bubble_ex, pc_redirect;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pipe_hazard_ctrl uut (
    .legacy_mode(legacy_mode), .id_rs(id_rs), .id_rt(id_rt),
    .id_use_rs(id_use_rs), .id_use_rt(id_use_rt), .id_branch(id_branch),
    .id_branch_taken(id_branch_taken), .ex_rd(ex_rd), .ex_wr(ex_wr),
    .ex_load(ex_load), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_load(mem_load),
    .wb_rd(wb_rd), .wb_wr(wb_wr), .fwd_rs_sel(fwd_rs_sel),
    .fwd_rt_sel(fwd_rt_sel), .hold_pc(hold_pc), .hold_ifid(hold_ifid),
    .bubble_ex(bubble_ex), .pc_redirect(pc_redirect)
  );

  task automatic idle();
    legacy_mode = 0; id_rs = 0; id_rt = 0; id_use_rs = 0; id_use_rt = 0;
    id_branch = 0; id_branch_taken = 0;
    ex_rd = 0; ex_wr = 0; ex_load = 0;
    mem_rd = 0; mem_wr = 0; mem_load = 0;
    wb_rd = 0; wb_wr = 0;
  endtask

  // apply on falling edge, outputs are combinational: sample 1 ns later
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic expect_out(string req, logic [1:0] e_rs, logic [1:0] e_rt,
                            logic e_stall, logic e_redir);
    #1;
    checks++;
    if (fwd_rs_sel !== e_rs || fwd_rt_sel !== e_rt ||
        {hold_pc, hold_ifid, bubble_ex} !== {3{e_stall}} || pc_redirect !== e_redir) begin
      errors++;
      $display("FAIL %s: got rs=%0d rt=%0d stall=%b%b%b redir=%b, expected rs=%0d rt=%0d stall=%b redir=%b",
               req, fwd_rs_sel, fwd_rt_sel, hold_pc, hold_ifid, bubble_ex, pc_redirect,
               e_rs, e_rt, e_stall, e_redir);
    end
  endtask

  task automatic t_idle();
    settle(); idle();
    expect_out("R3 idle", 2'd0, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_priority();
    settle(); idle();
    id_rs = 5; id_rt = 5; id_use_rs = 1; id_use_rt = 1;
    ex_rd = 5; ex_wr = 1; mem_rd = 5; mem_wr = 1; wb_rd = 5; wb_wr = 1;
    expect_out("R1 execute youngest", 2'd1, 2'd1, 1'b0, 1'b0);
    settle(); ex_wr = 0; ex_load = 1;
    expect_out("R9 execute write-enable low", 2'd2, 2'd2, 1'b0, 1'b0);
    settle(); mem_wr = 0;
    expect_out("R1 writeback", 2'd3, 2'd3, 1'b0, 1'b0);
    settle(); wb_wr = 0;
    expect_out("R1 register file", 2'd0, 2'd0, 1'b0, 1'b0);
    settle(); idle();
    id_rs = 3; id_rt = 4; id_use_rs = 1; id_use_rt = 1;
    ex_rd = 4; ex_wr = 1; mem_rd = 3; mem_wr = 1;
    expect_out("R1 split sources", 2'd2, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_zero_unused();
    settle(); idle();
    id_use_rs = 1; id_use_rt = 1; ex_rd = 0; ex_wr = 1; ex_load = 1;
    mem_wr = 1; wb_wr = 1;
    expect_out("R2 register zero", 2'd0, 2'd0, 1'b0, 1'b0);
    settle(); idle();
    id_rs = 6; id_rt = 6; ex_rd = 6; ex_wr = 1; ex_load = 1;
    expect_out("R3 unused operands", 2'd0, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_load_use();
    settle(); idle();
    id_rt = 8; id_use_rt = 1; ex_rd = 8; ex_wr = 1; ex_load = 1;
    expect_out("R4 load in execute", 2'd0, 2'd1, 1'b1, 1'b0);
    settle(); id_branch = 1; id_branch_taken = 1;
    expect_out("R8 taken branch while stalled", 2'd0, 2'd1, 1'b1, 1'b0);
    settle(); idle();
    id_rt = 8; id_use_rt = 1; mem_rd = 8; mem_wr = 1; mem_load = 1;
    expect_out("R5 load bypass from memory", 2'd0, 2'd2, 1'b0, 1'b0);
  endtask

  task automatic t_legacy();
    settle(); idle(); legacy_mode = 1;
    id_rs = 9; id_use_rs = 1; ex_rd = 9; ex_wr = 1; ex_load = 1;
    expect_out("R4 legacy first bubble", 2'd1, 2'd0, 1'b1, 1'b0);
    settle(); ex_wr = 0; ex_load = 0; mem_rd = 9; mem_wr = 1; mem_load = 1;
    expect_out("R6 legacy second bubble", 2'd2, 2'd0, 1'b1, 1'b0);
    settle(); mem_wr = 0; mem_load = 0; wb_rd = 9; wb_wr = 1;
    expect_out("R6 legacy writeback", 2'd3, 2'd0, 1'b0, 1'b0);
    settle(); wb_wr = 0; mem_wr = 1;
    expect_out("R6 legacy ALU bypass", 2'd2, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_branch();
    settle(); idle();
    id_rs = 10; id_use_rs = 1; id_branch = 1; id_branch_taken = 1;
    ex_rd = 10; ex_wr = 1;
    expect_out("R7 branch on execute result", 2'd1, 2'd0, 1'b1, 1'b0);
    settle(); id_branch = 0; id_branch_taken = 0;
    expect_out("R7 non-branch bypass", 2'd1, 2'd0, 1'b0, 1'b0);
    settle(); id_branch = 1; id_branch_taken = 1; ex_wr = 0;
    mem_rd = 10; mem_wr = 1;
    expect_out("R8 redirect with delay slot", 2'd2, 2'd0, 1'b0, 1'b1);
    settle(); id_branch_taken = 0;
    expect_out("R8 not taken", 2'd2, 2'd0, 1'b0, 1'b0);
  endtask

  initial begin
    idle();
    repeat (2) @(posedge clk);
    t_idle();
    t_priority();
    t_zero_unused();
    t_load_use();
    t_legacy();
    t_branch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule